// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of an 8-bit successive-approximation converter that sits directly on a microprocessor bus. The host starts a conversion by pulling chip-select and write low together. The block then searches for the result one bit per conversion clock, starting with the most significant bit. It presents each trial code to an external DAC and comparator and reads back a single comparator bit.

When the search finishes, the block copies the result into an output latch. One clock later it pulls its active-low interrupt low. A read with chip-select and read both low enables the latch onto the bus and clears the interrupt. The bus drive is modelled as a separate enable rather than a tri-state pin.

A start that arrives during a conversion abandons that conversion, and the previous result stays in the latch. Free-running operation needs no extra logic: the interrupt output is wired back to the write input with chip-select held low, and one forced low pulse on write after power-up starts the chain.

Top module: `sar_bus_conv`

## Requirements
- R1: While the synchronous active-low reset is low, on each clock edge the block sets `intr_n` to 1 and sets `trial_code` and `data_out` to 0x00.
- R2: A clock edge that samples `cs_n` and `wr_n` both low sets the start flop. `intr_n` then goes high at the following edge, not at the sampling edge.
- R3: The first trial code 0x80 appears two edges after the last edge at which the start request is sampled. Each of the following 8 edges resolves one bit, most significant first. At each of these edges the current bit is kept when `cmp_ge`=1 (input at or above the trial) and cleared otherwise, and the next lower bit is set to 1.
- R4: The result equals the largest code that the comparator still accepts. A comparator that rejects every trial gives 0x00, and one that accepts every trial gives 0xFF.
- R5: For a single-cycle start sampled at edge E0, `data_out` takes the new result at edge E0+11 and `intr_n` goes low at edge E0+12, one clock after the data.
- R6: A start sampled while a conversion is running abandons that conversion. `data_out` keeps the previous result and `intr_n` stays high until the restarted conversion completes.
- R7: An edge that samples `cs_n` and `rd_n` both low clears the interrupt, so `intr_n` is 1 after that edge.
- R8: If the completion that sets the interrupt and a read fall on the same edge, the completion wins and `intr_n` goes low. A read at a later edge clears it.
- R9: `data_oe` is 1 exactly while `cs_n` and `rd_n` are both low. It has no clock delay.
- R10: With `cs_n` held low, `wr_n` tied to `intr_n` and one forced write pulse, conversions repeat on their own with 14 clocks between successive falling edges of `intr_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low; starts a conversion when `cs_n` is also low |
| rd_n | input | 1 | Read strobe, active low |
| cmp_ge | input | 1 | Comparator result: 1 when the analog input is at or above the trial code |
| trial_code | output | 8 | Trial code driven to the external DAC |
| data_out | output | 8 | Output latch contents; these reach the bus only while `data_oe` is 1 |
| data_oe | output | 1 | Bus drive enable; 0 means high impedance |
| intr_n | output | 1 | Conversion-complete interrupt, active low |

## Verification
Two functions can meet on one clock edge: the completion that sets the interrupt, and a read that clears it. The bench holds chip-select and read low across the exact edge at which the interrupt is due. It expects the interrupt to go low there and to go high only at the next edge. A second collision, a restart that lands on the commit stage of a running conversion, is provoked by issuing a new start halfway through a search. It is judged by the latch keeping the earlier result, and the interrupt staying high, at the edges where the abandoned search would have committed.

// File: rtl/sar_pkg.sv
// Package: shared constants for the SAR conversion sequencer.
// Assumes a single conversion clock domain for the whole block.
package sar_pkg;
    parameter int unsigned SAR_W = 8;
endpackage

// File: rtl/sar_start_ff.sv
// Module: start flop.
// Samples the chip-select/write pair on each clock and holds a request flag
// while both are low. The flag clears on the first clock after the strobe
// ends. Assumes the strobes are already synchronous to clk.
module sar_start_ff (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic wr_n,
    output logic start_q
);
    // Purpose: register the start request for the rest of the block.
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= ~cs_n & ~wr_n;
    end
endmodule

// File: rtl/sar_walker.sv
// Module: walking-one sequencer and successive-approximation register.
// While a start is pending it clears everything and arms the seed flop.
// After that a single marker bit walks from MSB to LSB, one position per
// clock, and each position resolves one bit of the trial code. done_q pulses
// for one clock after the LSB decision. Assumes cmp_ge reflects the trial
// code registered on the previous edge.
module sar_walker #(
    parameter int unsigned W = sar_pkg::SAR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_q,
    input  logic         cmp_ge,
    output logic [W-1:0] trial,
    output logic         done_q
);
    localparam logic [W-1:0] MSB_ONE = {1'b1, {(W-1){1'b0}}};

    logic         seed_q;
    logic [W-1:0] marker;

    // Purpose: arm, walk the marker and resolve one trial bit per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seed_q <= 1'b0;
            marker <= '0;
            trial  <= '0;
            done_q <= 1'b0;
        end else if (start_q) begin
            seed_q <= 1'b1;
            marker <= '0;
            trial  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= marker[0];
            if (seed_q) begin
                seed_q <= 1'b0;
                marker <= MSB_ONE;
                trial  <= MSB_ONE;
            end else begin
                marker <= marker >> 1;
                for (int i = 0; i < int'(W); i++) begin
                    if (marker[i]) begin
                        trial[i] <= cmp_ge;
                        if (i > 0) trial[i-1] <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sar_out_stage.sv
// Module: output latch and interrupt flag.
// Captures the finished code when the sequencer reports done. The interrupt
// is raised one clock later; a completion beats a read on the same edge, and
// a start clears everything pending. Bus drive is a combinational enable.
module sar_out_stage #(
    parameter int unsigned W = sar_pkg::SAR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_q,
    input  logic         done_q,
    input  logic [W-1:0] trial,
    input  logic         cs_n,
    input  logic         rd_n,
    output logic [W-1:0] data_q,
    output logic         pend_q,
    output logic         intr_n,
    output logic         data_oe
);
    logic flag_q;
    logic rd_sel;

    // Purpose: decode the read strobe pair.
    always_comb rd_sel = ~cs_n & ~rd_n;

    // Purpose: latch the result, then set or clear the interrupt flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            pend_q <= 1'b0;
            flag_q <= 1'b0;
        end else if (start_q) begin
            pend_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            pend_q <= done_q;
            if (done_q) data_q <= trial;
            if (pend_q)      flag_q <= 1'b1;
            else if (rd_sel) flag_q <= 1'b0;
        end
    end

    // Purpose: drive the active-low interrupt and the bus enable.
    always_comb begin
        intr_n  = ~flag_q;
        data_oe = rd_sel;
    end
endmodule

// File: rtl/sar_bus_conv.sv
// Module: top of the SAR conversion sequencer with bus interface.
// Connects the start flop, the walking-one sequencer and the output stage.
// Assumes an external DAC and comparator close the loop through trial_code
// and cmp_ge within one clock.
module sar_bus_conv #(
    parameter int unsigned W = sar_pkg::SAR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         wr_n,
    input  logic         rd_n,
    input  logic         cmp_ge,
    output logic [W-1:0] trial_code,
    output logic [W-1:0] data_out,
    output logic         data_oe,
    output logic         intr_n
);
    logic start_q;
    logic done_q;
    logic pend_q;

    sar_start_ff u_start (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .start_q(start_q)
    );

    sar_walker #(.W(W)) u_walk (
        .clk(clk), .rst_n(rst_n), .start_q(start_q), .cmp_ge(cmp_ge),
        .trial(trial_code), .done_q(done_q)
    );

    sar_out_stage #(.W(W)) u_out (
        .clk(clk), .rst_n(rst_n), .start_q(start_q), .done_q(done_q),
        .trial(trial_code), .cs_n(cs_n), .rd_n(rd_n), .data_q(data_out),
        .pend_q(pend_q), .intr_n(intr_n), .data_oe(data_oe)
    );
endmodule

// File: rtl/sar_bus_conv_chk.sv
// Module: property checker for sar_bus_conv, attached with bind.
// Observes ports plus the start and pending-interrupt nets between stages.
module sar_bus_conv_chk #(
    parameter int unsigned W = sar_pkg::SAR_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cs_n,
    input logic         wr_n,
    input logic         rd_n,
    input logic [W-1:0] trial_code,
    input logic [W-1:0] data_out,
    input logic         intr_n,
    input logic         start_q,
    input logic         pend_q
);
    // R1: reset forces idle outputs
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (intr_n && trial_code == '0 && data_out == '0));

    // R2: a sampled start releases the interrupt one edge later
    a_r2_start_clears_intr: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n) |=> ##1 intr_n);

    // R5: a latch update is followed one clock later by the interrupt
    a_r5_data_then_intr: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(data_out) && $past(cs_n || wr_n)) |=> $fell(intr_n));

    // R6: a pending start blocks any latch update
    a_r6_start_holds_data: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> $stable(data_out));

    // R7: a read with no completion due clears the interrupt
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !rd_n && !pend_q) |=> intr_n);

    // R8: a due completion sets the interrupt even during a read
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !start_q) |=> !intr_n);
endmodule

bind sar_bus_conv sar_bus_conv_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .trial_code(trial_code), .data_out(data_out), .intr_n(intr_n),
    .start_q(start_q), .pend_q(pend_q)
);

// File: tb/sim_sar_bus_conv.sv
// Bench for sar_bus_conv: table-driven sweep of target codes, then directed
// tests for start, abort, read collision and free-running operation.
module sim_sar_bus_conv;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_drv = 1'b1;
    logic       wr_drv = 1'b1;
    logic       wr_force = 1'b1;
    logic       fr = 1'b0;
    logic       rd_drv = 1'b1;
    logic [7:0] tgt = 8'h00;
    logic [7:0] trial_code;
    logic [7:0] data_out;
    logic       data_oe;
    logic       intr_n;
    logic       wr_n;
    logic       cmp_ge;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         ended = 1'b0;

    localparam int NV = 9;
    localparam logic [7:0] VEC [NV] = '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h01,
                                        8'hFE, 8'h55, 8'hAA, 8'h3C};

    always #2.5 clk = ~clk;

    assign wr_n   = fr ? (intr_n & wr_force) : wr_drv;
    assign cmp_ge = (tgt >= trial_code);

    sar_bus_conv u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_drv), .wr_n(wr_n), .rd_n(rd_drv),
        .cmp_ge(cmp_ge), .trial_code(trial_code), .data_out(data_out),
        .data_oe(data_oe), .intr_n(intr_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Called at a negedge; returns at the negedge after the sampling edge E0.
    task automatic start_conv();
        cs_drv = 1'b0; wr_drv = 1'b0;
        @(negedge clk);
        cs_drv = 1'b1; wr_drv = 1'b1;
    endtask

    task automatic do_read();
        cs_drv = 1'b0; rd_drv = 1'b0;
        @(negedge clk);
        cs_drv = 1'b1; rd_drv = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 intr_n", intr_n, 1);
        chk("R1 data_out", data_out, 0);
        chk("R1 trial_code", trial_code, 0);
        chk("R9 oe idle", data_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table sweep: R3, R4, R5, R7, R9
        for (int v = 0; v < NV; v++) begin
            tgt = VEC[v];
            start_conv();
            @(negedge clk);
            chk("R2 intr high after start", intr_n, 1);
            for (int k = 0; k <= 8; k++) begin
                @(negedge clk);
                chk("R3 trial step", trial_code,
                    (tgt & ~(8'hFF >> k)) | (8'h80 >> k));
            end
            @(negedge clk);
            chk("R4 result", data_out, tgt);
            chk("R5 intr still high at latch edge", intr_n, 1);
            @(negedge clk);
            chk("R5 intr low one clock after latch", intr_n, 0);
            cs_drv = 1'b0; rd_drv = 1'b0;
            #1 chk("R9 oe on read", data_oe, 1);
            @(negedge clk);
            chk("R7 read clears intr", intr_n, 1);
            cs_drv = 1'b1; rd_drv = 1'b1;
            #1 chk("R9 oe off", data_oe, 0);
        end

        // R2: interrupt clears one edge after the start, not at it
        tgt = 8'h11;
        start_conv();
        repeat (12) @(negedge clk);
        chk("R5 intr low", intr_n, 0);
        start_conv();
        chk("R2 intr still low at sampling edge", intr_n, 0);
        @(negedge clk);
        chk("R2 intr high next edge", intr_n, 1);
        repeat (11) @(negedge clk);
        chk("R4 result 0x11", data_out, 8'h11);
        chk("R5 intr low", intr_n, 0);
        do_read();

        // R6: restart mid-conversion keeps old data
        tgt = 8'h5A;
        start_conv();
        repeat (5) @(negedge clk);
        start_conv();
        repeat (5) @(negedge clk);
        chk("R6 data kept", data_out, 8'h11);
        chk("R6 intr high", intr_n, 1);
        @(negedge clk);
        chk("R6 intr high at old commit", intr_n, 1);
        repeat (5) @(negedge clk);
        chk("R6 new result", data_out, 8'h5A);
        chk("R6 intr high before new commit", intr_n, 1);
        @(negedge clk);
        chk("R6 intr low after restart done", intr_n, 0);
        do_read();

        // R8: completion and read on the same edge
        tgt = 8'h9C;
        start_conv();
        repeat (11) @(negedge clk);
        cs_drv = 1'b0; rd_drv = 1'b0;
        @(negedge clk);
        chk("R8 completion wins", intr_n, 0);
        @(negedge clk);
        chk("R7 later read clears", intr_n, 1);
        chk("R4 result 0x9C", data_out, 8'h9C);
        cs_drv = 1'b1; rd_drv = 1'b1;

        // R10: free-running loop
        tgt = 8'hC3;
        @(negedge clk);
        fr = 1'b1; cs_drv = 1'b0; wr_force = 1'b0;
        @(negedge clk);
        wr_force = 1'b1;
        cnt = 0;
        while (intr_n !== 1'b0 && cnt < 100) begin @(negedge clk); cnt++; end
        chk("R10 first completion", intr_n, 0);
        chk("R10 result", data_out, 8'hC3);
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (intr_n !== 1'b1 && cnt < 100);
        do begin @(negedge clk); cnt++; end while (intr_n !== 1'b0 && cnt < 100);
        chk("R10 period", cnt, 14);
        chk("R10 repeated result", data_out, 8'hC3);
        fr = 1'b0; cs_drv = 1'b1;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule